// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is a 32-line general-purpose I/O port sitting on a plain single-cycle register bus. The bus has a word address, a write strobe, write data and a combinational read-data return. Software chooses a direction and an open-drain mode for each line, loads an output latch, and decides per line whether the sampled pin level may reach the data register. The block drives per-line output values and output enables toward the pads. It takes raw pin levels, which it passes through a two-flop synchronizer first.

Register bits run opposite to line numbers: line `n` lives in bit `NLINES-1-n` of every register, so line 0 is the most significant bit. A build-time selection can make four lines input-only, either the top four lines or the bottom four. Edge or level event detection is handled by a separate block and is not part of this one.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, the direction, open-drain, output latch and input-enable registers all read 0, and every `pin_oe` and `pin_out` bit is 0.
- R2: Line `n` (pin vector index `n`) corresponds to bit `31-n` of every register, so line 0 is bit 31 and line 31 is bit 0.
- R3: A line whose direction bit is 1 and open-drain bit is 0 has `pin_oe`=1 and `pin_out` equal to its latch bit. A line whose direction bit is 0 has `pin_oe`=0 and `pin_out`=0.
- R4: An output line whose open-drain bit is 1 drives `pin_out`=0 with `pin_oe`=1 when its latch bit is 0, and releases (`pin_oe`=0) when its latch bit is 1. It never drives a 1.
- R5: Reading the data register (word address 2) returns, for an input line, the synchronized pin level when its input-enable bit (register at word address 6) is 1, and 0 when that bit is 0.
- R6: Reading the data register returns the latch bit for an output line, whatever the pin level.
- R7: A pin change becomes visible in a data register read after exactly two rising clock edges. It is not visible after one.
- R8: With the top-lines variant, direction bits for lines 28..31 (bits 3..0) stay 0 when written with 1. With the bottom-lines variant, lines 0..3 (bits 31..28) do so. The other lines are unaffected.
- R9: Word addresses 3, 4, 5 and 7 read as 0, and writes to them change no register.
- R10: The direction (word address 0), open-drain (word address 1) and input-enable (word address 6) registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word address of the register |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Raw pin levels, index = line number |
| pin_out | output | 32 | Output value per line |
| pin_oe | output | 32 | Output enable per line |

## Verification
A register write and a pin transition can land in the same cycle. So can the view in the data register of a line that has just changed direction and the synchronizer output of that same line. The vector table changes the pins in the same cycle as each register write, including the write that turns sensing lines 4..7 into outputs. It then expects the read to show only the latch for those lines and the gated pin for the rest. A directed step moves one enabled input pin while the data address is held, and checks the read after one edge and again after two.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and types for the GPIO port register block.
// Assumes word addressing on the register bus.
package gpio_port_pkg;

    // Which group of lines, if any, is built as input-only.
    typedef enum logic [1:0] {
        RO_NONE         = 2'd0,
        RO_TOP_LINES    = 2'd1,
        RO_BOTTOM_LINES = 2'd2
    } ro_group_e;

    // Word addresses of the four registers.
    localparam int WORD_DIR  = 0;
    localparam int WORD_OD   = 1;
    localparam int WORD_DATA = 2;
    localparam int WORD_IBE  = 6;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent. No multi-bit coherence is implied.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;

    // Purpose: two register stages that resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module: writable control state of the port (direction, open-drain,
// output latch, input enable), held in register-bit order.
// Assumes one write per cycle. Bits set in RO_MASK can never become outputs.
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int                NLINES  = 32,
    parameter int                ADDR_W  = 3,
    parameter logic [NLINES-1:0] RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] dir_q,
    output logic [NLINES-1:0] od_q,
    output logic [NLINES-1:0] dat_q,
    output logic [NLINES-1:0] ibe_q
);

    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(WORD_DIR);
    localparam logic [ADDR_W-1:0] A_OD   = ADDR_W'(WORD_OD);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(WORD_DATA);
    localparam logic [ADDR_W-1:0] A_IBE  = ADDR_W'(WORD_IBE);

    logic wr_dir, wr_od, wr_dat, wr_ibe;

    // Purpose: decode the write strobe into one enable per register.
    always_comb begin
        wr_dir = bus_we && (bus_addr == A_DIR);
        wr_od  = bus_we && (bus_addr == A_OD);
        wr_dat = bus_we && (bus_addr == A_DATA);
        wr_ibe = bus_we && (bus_addr == A_IBE);
    end

    // Purpose: direction register. Input-only bits are forced to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= bus_wdata & ~RO_MASK;
    end

    // Purpose: open-drain select register.
    always_ff @(posedge clk) begin
        if (!rst_n)     od_q <= '0;
        else if (wr_od) od_q <= bus_wdata;
    end

    // Purpose: output latch, kept for every line whatever its direction.
    always_ff @(posedge clk) begin
        if (!rst_n)      dat_q <= '0;
        else if (wr_dat) dat_q <= bus_wdata;
    end

    // Purpose: input buffer enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ibe_q <= '0;
        else if (wr_ibe) ibe_q <= bus_wdata;
    end

endmodule

// File: rtl/gpio_pin_drive.sv
// Module: turns register-order control bits into line-order pad controls.
// Assumes line n uses register bit NLINES-1-n.
module gpio_pin_drive #(
    parameter int NLINES = 32
) (
    input  logic [NLINES-1:0] dir_q,
    input  logic [NLINES-1:0] od_q,
    input  logic [NLINES-1:0] dat_q,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe
);

    // Purpose: one driver slice per line, taken from the mirrored bit.
    for (genvar l = 0; l < NLINES; l++) begin : g_line
        localparam int B = NLINES - 1 - l;
        assign pin_oe[l]  = dir_q[B] & (~od_q[B] | ~dat_q[B]);
        assign pin_out[l] = dir_q[B] & ~od_q[B] & dat_q[B];
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Module: read-data selection. The data view merges the latch of output
// lines with the enabled synchronized pins of input lines.
// Assumes pin_sync is in line order and the registers are in bit order.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NLINES-1:0] dir_q,
    input  logic [NLINES-1:0] od_q,
    input  logic [NLINES-1:0] dat_q,
    input  logic [NLINES-1:0] ibe_q,
    input  logic [NLINES-1:0] pin_sync,
    output logic [NLINES-1:0] bus_rdata
);

    logic [NLINES-1:0] pin_bits;
    logic [NLINES-1:0] data_view;

    // Purpose: mirror synchronized pins into register-bit order.
    for (genvar l = 0; l < NLINES; l++) begin : g_mirror
        assign pin_bits[NLINES-1-l] = pin_sync[l];
    end

    // Purpose: build the data register view and select by address.
    always_comb begin
        data_view = (dir_q & dat_q) | (~dir_q & ibe_q & pin_bits);
        unique case (int'(bus_addr))
            WORD_DIR:  bus_rdata = dir_q;
            WORD_OD:   bus_rdata = od_q;
            WORD_DATA: bus_rdata = data_view;
            WORD_IBE:  bus_rdata = ibe_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_regs.sv
// Module: top of the GPIO port. Wires the synchronizer, control registers,
// pad driver and read mux. Assumes a single-cycle bus with combinational
// read data and at most one write per cycle.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int        NLINES   = 32,
    parameter int        ADDR_W   = 3,
    parameter int        RO_COUNT = 4,
    parameter ro_group_e RO_GROUP = RO_NONE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe
);

    // Purpose: register-order mask of the lines built as input-only.
    function automatic logic [NLINES-1:0] ro_bits();
        logic [NLINES-1:0] m;
        m = '0;
        for (int l = 0; l < NLINES; l++) begin
            if ((RO_GROUP == RO_TOP_LINES && l >= NLINES - RO_COUNT) ||
                (RO_GROUP == RO_BOTTOM_LINES && l < RO_COUNT))
                m[NLINES-1-l] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NLINES-1:0] RO_MASK = ro_bits();

    logic [NLINES-1:0] dir_q, od_q, dat_q, ibe_q;
    logic [NLINES-1:0] pin_sync;

    gpio_in_sync #(.W(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    gpio_ctrl_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W), .RO_MASK(RO_MASK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .dir_q     (dir_q),
        .od_q      (od_q),
        .dat_q     (dat_q),
        .ibe_q     (ibe_q)
    );

    gpio_pin_drive #(.NLINES(NLINES)) u_drive (
        .dir_q   (dir_q),
        .od_q    (od_q),
        .dat_q   (dat_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    gpio_read_mux #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_rmux (
        .bus_addr  (bus_addr),
        .dir_q     (dir_q),
        .od_q      (od_q),
        .dat_q     (dat_q),
        .ibe_q     (ibe_q),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/gpio_port_regs_chk.sv
// Module: property checker for gpio_port_regs, attached by bind.
// Assumes it sees the top's ports plus its register and synchronizer state.
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int                NLINES  = 32,
    parameter int                ADDR_W  = 3,
    parameter logic [NLINES-1:0] RO_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NLINES-1:0] bus_wdata,
    input logic [NLINES-1:0] bus_rdata,
    input logic [NLINES-1:0] pin_in,
    input logic [NLINES-1:0] pin_out,
    input logic [NLINES-1:0] pin_oe,
    input logic [NLINES-1:0] dir_q,
    input logic [NLINES-1:0] od_q,
    input logic [NLINES-1:0] ibe_q,
    input logic [NLINES-1:0] pin_sync
);

    logic [NLINES-1:0] dir_ln, od_ln, wd_ln;
    logic [1:0]        since_rst;

    for (genvar l = 0; l < NLINES; l++) begin : g_ln
        assign dir_ln[l] = dir_q[NLINES-1-l];
        assign od_ln[l]  = od_q[NLINES-1-l];
        assign wd_ln[l]  = bus_wdata[NLINES-1-l];
    end

    // Purpose: count edges since reset, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && dir_q == '0 && ibe_q == '0));

    // R3, R2
    a_r3_push_pull_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(WORD_DATA)) |=>
        ((pin_out & dir_ln & ~od_ln) == ($past(wd_ln) & dir_ln & ~od_ln)));

    // R3
    a_r3_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_ln) == '0);

    // R4
    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & od_ln) == '0);

    // R5
    a_r5_gate_closed_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(WORD_DATA)) |-> ((bus_rdata & ~dir_q & ~ibe_q) == '0));

    // R7
    a_r7_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2) |-> (pin_sync == $past(pin_in, 2)));

    // R8
    a_r8_input_only_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & RO_MASK) == '0);

    // R9
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr inside {3'd3, 3'd4, 3'd5, 3'd7}) |-> (bus_rdata == '0));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .NLINES(NLINES), .ADDR_W(ADDR_W), .RO_MASK(RO_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .ibe_q     (ibe_q),
    .pin_sync  (pin_sync)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
    import gpio_port_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rd0, rd1, rd2, out0, out1, out2, oe0, oe1, oe2;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gpio_port_regs u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .pin_in(pin_in), .pin_out(out0), .pin_oe(oe0));
    gpio_port_regs #(.RO_GROUP(RO_TOP_LINES)) u1 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd1), .pin_in(pin_in),
        .pin_out(out1), .pin_oe(oe1));
    gpio_port_regs #(.RO_GROUP(RO_BOTTOM_LINES)) u2 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rd2), .pin_in(pin_in),
        .pin_out(out2), .pin_oe(oe2));

    typedef struct packed {
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [31:0] pins;
        logic [2:0]  raddr;
        logic [31:0] exp_rd;
        logic [31:0] exp_oe;
        logic [31:0] exp_out;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{3'd6, 32'hFFFFFFFF, 32'h000000F0, 3'd2, 32'h0F000000, 32'h0,        32'h0,        8'd5},  // R5 R2
        '{3'd0, 32'hFF000000, 32'h000000F0, 3'd2, 32'h00000000, 32'h000000FF, 32'h0,        8'd6},  // R6
        '{3'd2, 32'hA5000000, 32'h000000F0, 3'd2, 32'hA5000000, 32'h000000FF, 32'h000000A5, 8'd3},  // R3
        '{3'd1, 32'hF0000000, 32'h00010000, 3'd2, 32'hA5008000, 32'h000000FA, 32'h000000A0, 8'd4},  // R4
        '{3'd6, 32'h0000FFFF, 32'h00010100, 3'd2, 32'hA5008000, 32'h000000FA, 32'h000000A0, 8'd5},  // R5
        '{3'd3, 32'hFFFFFFFF, 32'h00010100, 3'd1, 32'hF0000000, 32'h000000FA, 32'h000000A0, 8'd9},  // R9
        '{3'd5, 32'h12345678, 32'h00010100, 3'd7, 32'h00000000, 32'h000000FA, 32'h000000A0, 8'd9},  // R9
        '{3'd0, 32'h0000000F, 32'h00010100, 3'd0, 32'h0000000F, 32'hF0000000, 32'h00000000, 8'd10}  // R10
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, $sformatf("u0 read addr %0d", a), rd0, exp);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_check("R1", 3'd0, 32'h0);
        rd_check("R1", 3'd1, 32'h0);
        rd_check("R1", 3'd2, 32'h0);
        rd_check("R1", 3'd6, 32'h0);
        check("R1", "pin_oe", oe0, 32'h0);
        check("R1", "pin_out", out0, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pin_in = TBL[i].pins;
            bus_addr = TBL[i].waddr; bus_wdata = TBL[i].wdata; bus_we = 1'b1;
            @(negedge clk);
            bus_we = 1'b0;
            repeat (2) @(negedge clk);
            bus_addr = TBL[i].raddr;
            #1;
            check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d rdata", i), rd0, TBL[i].exp_rd);
            check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d pin_oe", i), oe0, TBL[i].exp_oe);
            check($sformatf("R%0d", TBL[i].req), $sformatf("vec %0d pin_out", i), out0, TBL[i].exp_out);
        end

        // R7: synchronizer latency, line 20 (bit 11) enabled as input
        @(negedge clk);
        pin_in = 32'h0;
        bus_addr = 3'd2;
        repeat (3) @(negedge clk);
        pin_in = 32'h00100000;
        @(negedge clk);
        #1;
        check("R7", "after one edge", rd0 & 32'h800, 32'h0);
        @(negedge clk);
        #1;
        check("R7", "after two edges", rd0 & 32'h800, 32'h800);

        // R8: input-only variants, plus R3 R4 on the full-output port
        wr(3'd0, 32'hFFFFFFFF);
        #1;
        check("R8", "u1 dir readback", rd1, 32'hFFFFFFF0);
        check("R8", "u2 dir readback", rd2, 32'h0FFFFFFF);
        check("R8", "u1 pin_oe", oe1, 32'h0FFFFFFA);
        check("R8", "u2 pin_oe", oe2, 32'hFFFFFFF0);
        check("R4", "u0 pin_oe all outputs", oe0, 32'hFFFFFFFA);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1", 3'd0, 32'h0);
        rd_check("R1", 3'd1, 32'h0);
        rd_check("R1", 3'd6, 32'h0);
        check("R1", "pin_oe after reset", oe0, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule